// File: doc/BRIEF.md
# Quad-Phase Move Executor

This block runs two single-word, 16-bit data-move instructions on an 8-bit working register. The first puts an immediate byte from the instruction word into the working register. The second copies the working register into a data-memory location.

Every instruction takes one instruction cycle of four clocks. A free-running 2-bit phase counter marks the four clocks: decode (Q1), operand read (Q2), process (Q3) and write-back (Q4). The instruction word is captured at the end of Q1. The block sends the decoded 8-bit file field and the bank-select flag to an external address generator. It samples the effective address that comes back at the end of Q2. Neither move touches any status flag, so the block has no flag outputs. Any other opcode passes through the four phases with no effect.

Top module: `qmove_core`

## Requirements
- R1: While `rst_n` is low, at each clock the working register is cleared to 0x00, the phase counter is forced to Q1 (`phase_o` = 0) and `mem_we_o` stays low.
- R2: Out of reset, `phase_o` steps through 0 (Q1), 1 (Q2), 2 (Q3) and 3 (Q4), one step per clock, and then wraps to 0.
- R3: `instr_i` and `instr_valid_i` are sampled only at the clock edge that ends a Q1 cycle. Changes to them during Q2 to Q4 do not affect the instruction in progress.
- R4: A word whose bits [15:8] equal 0x0E loads bits [7:0] into the working register. The new value shows on `w_o` from the Q1 cycle that follows the Q4 of that instruction.
- R5: A word whose bits [15:9] equal 7'b0110111 is a store. `mem_we_o` is high for exactly the one Q4 clock of that instruction. During that clock `mem_wdata_o` equals `w_o`, and `mem_addr_o` equals `eff_addr_i` as sampled at the edge that ends Q2.
- R6: A store leaves the working register unchanged.
- R7: After the Q1 capture edge, `fsel_o` shows bits [7:0] and `bank_o` shows bit 8 of the captured word, and both hold until the next capture. A word captured with `instr_valid_i` low reads as all zeros.
- R8: A word matching neither opcode, or any word captured while `instr_valid_i` is low, causes no memory write and no change to the working register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; one instruction cycle takes four edges |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 16 | Instruction word, sampled at the end of Q1 |
| instr_valid_i | input | 1 | Qualifies `instr_i` at the Q1 capture |
| eff_addr_i | input | ADDR_W (12) | Effective data address from the external generator, sampled at the end of Q2 |
| fsel_o | output | 8 | File field of the captured instruction |
| bank_o | output | 1 | Bank-select flag of the captured instruction |
| phase_o | output | 2 | Current phase, 0 to 3 for Q1 to Q4 |
| w_o | output | 8 | Working register |
| mem_addr_o | output | ADDR_W (12) | Data-memory write address |
| mem_wdata_o | output | 8 | Data-memory write data |
| mem_we_o | output | 1 | Data-memory write enable, high in Q4 of a store |

## Verification
The hardest cases to reach from the ports are those where the sampling moment decides the outcome. One is a store placed directly after a load, which must write the value the load has just produced. Another is an instruction or address input that changes during Q2 to Q4 and must be ignored. The bench changes `eff_addr_i` on every clock and drives the inverted word onto `instr_i` during the three clocks after each capture, with a toggling valid strobe. The only address that can match is the one present at the Q2 edge, and only the word present at Q1 can take effect. Load-then-store pairs, stores of 0x00 and 0xFF, invalid captures and unknown opcodes are mixed into a long pseudo-random stream.

// File: rtl/qmove_pkg.sv
// Shared types and opcode classification for the quad-phase move executor.
// Assumes 16-bit instruction words and an 8-bit working register.
package qmove_pkg;

    localparam int IWORD_W = 16;
    localparam int BYTE_W  = 8;

    localparam logic [7:0] LDLIT_PREFIX = 8'h0E;
    localparam logic [6:0] STW_PREFIX   = 7'b0110111;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_LDLIT = 2'd1,
        OP_STW   = 2'd2
    } op_kind_t;

    // Maps an instruction word to the operation it performs.
    function automatic op_kind_t classify(input logic [IWORD_W-1:0] word);
        if (word[15:8] == LDLIT_PREFIX)
            return OP_LDLIT;
        else if (word[15:9] == STW_PREFIX)
            return OP_STW;
        else
            return OP_NOP;
    endfunction

endpackage

// File: rtl/qmove_phase.sv
// Free-running four-phase sequencer. Assumes nothing about its inputs:
// synchronous active-low reset returns it to Q1, and it advances every clock.
module qmove_phase
    import qmove_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase_o
);

    phase_t phase_q;

    // Advance one phase per clock, wrapping Q4 back to Q1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_Q1;
        else
            phase_q <= phase_t'(phase_q + 2'd1);
    end

    assign phase_o = phase_q;

    // R2: Q1 can only follow Q4.
    p_no_early_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_Q4) |=> (phase_q != PH_Q1));

endmodule

// File: rtl/qmove_decode.sv
// Instruction capture and decode. Latches the word only at the end of Q1.
// An unqualified word is replaced by zero, which decodes as a no-op.
// Assumes the phase input comes from qmove_phase.
module qmove_decode
    import qmove_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  phase_t              phase_i,
    input  logic [IWORD_W-1:0]  instr_i,
    input  logic                valid_i,
    output op_kind_t            kind_o,
    output logic [BYTE_W-1:0]   lit_o,
    output logic [BYTE_W-1:0]   fsel_o,
    output logic                bank_o
);

    logic [IWORD_W-1:0] ir_q;
    op_kind_t           kind_q;
    logic [IWORD_W-1:0] ir_next;

    // Replace an unqualified word with zero before it is stored.
    always_comb begin
        ir_next = valid_i ? instr_i : '0;
    end

    // Capture the word and its class at the Q1 boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            kind_q <= OP_NOP;
        end else if (phase_i == PH_Q1) begin
            ir_q   <= ir_next;
            kind_q <= classify(ir_next);
        end
    end

    assign kind_o = kind_q;
    assign lit_o  = ir_q[7:0];
    assign fsel_o = ir_q[7:0];
    assign bank_o = ir_q[8];

    // R3: the decoded operation is frozen outside the capture phase.
    p_hold_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != PH_Q1) |=> ($stable(kind_q) && $stable(ir_q)));

endmodule

// File: rtl/qmove_datapath.sv
// Operand, process and write-back stages for the two moves. Q2 reads the
// operand and samples the external address, Q3 passes the operand through,
// and Q4 writes the working register or drives the memory write port.
// Assumes phase and kind come from the sequencer and the decoder.
module qmove_datapath
    import qmove_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_i,
    input  op_kind_t          kind_i,
    input  logic [BYTE_W-1:0] lit_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    output logic [BYTE_W-1:0] w_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o
);

    logic [BYTE_W-1:0] w_q;
    logic [BYTE_W-1:0] opnd_q;
    logic [BYTE_W-1:0] res_q;
    logic [ADDR_W-1:0] addr_q;

    // Q2: read the literal or W, and sample the generated address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
            addr_q <= '0;
        end else if (phase_i == PH_Q2) begin
            opnd_q <= (kind_i == OP_LDLIT) ? lit_i : w_q;
            addr_q <= eff_addr_i;
        end
    end

    // Q3: the moves pass the operand through without modification.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (phase_i == PH_Q3)
            res_q <= opnd_q;
    end

    // Q4: only a literal load updates the working register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            w_q <= '0;
        else if (phase_i == PH_Q4 && kind_i == OP_LDLIT)
            w_q <= res_q;
    end

    assign w_o         = w_q;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = res_q;
    assign mem_we_o    = (phase_i == PH_Q4) && (kind_i == OP_STW);

    // R5: a write happens only in Q4.
    p_we_in_q4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (phase_i == PH_Q4));

    // R5: a write lasts a single clock.
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R5: stored data equals the working register.
    p_wdata_is_w_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_wdata_o == w_q));

    // R6 and R8: W changes only at the Q4 edge of a load.
    p_w_only_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_i == PH_Q4 && kind_i == OP_LDLIT) |=> $stable(w_q));

endmodule

// File: rtl/qmove_core.sv
// Top of the quad-phase move executor: sequencer, decoder and datapath.
// Assumes an external address generator turns fsel_o/bank_o into eff_addr_i
// before the end of Q2.
module qmove_core
    import qmove_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       instr_i,
    input  logic              instr_valid_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    output logic [7:0]        fsel_o,
    output logic              bank_o,
    output logic [1:0]        phase_o,
    output logic [7:0]        w_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o
);

    phase_t            phase;
    op_kind_t          kind;
    logic [BYTE_W-1:0] lit;

    qmove_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    qmove_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .instr_i (instr_i),
        .valid_i (instr_valid_i),
        .kind_o  (kind),
        .lit_o   (lit),
        .fsel_o  (fsel_o),
        .bank_o  (bank_o)
    );

    qmove_datapath #(.ADDR_W(ADDR_W)) u_datapath (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .kind_i      (kind),
        .lit_i       (lit),
        .eff_addr_i  (eff_addr_i),
        .w_o         (w_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o)
    );

    assign phase_o = phase;

    // R8: a capture with no valid strobe never produces a write.
    p_nop_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q1 && !instr_valid_i) |=> ##2 !mem_we_o);

endmodule

// File: tb/test_qmove_core.sv
module test_qmove_core;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       instr_i = 16'h0000;
    logic              instr_valid_i = 1'b0;
    logic [ADDR_W-1:0] eff_addr_i = '0;
    logic [7:0]        fsel_o;
    logic              bank_o;
    logic [1:0]        phase_o;
    logic [7:0]        w_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [7:0]        mem_wdata_o;
    logic              mem_we_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit started = 0;

    // Reference model state.
    int m_ph = 0;
    int m_w = 0;
    int m_ir = 0;
    int m_kind = 0;   // 0 none, 1 load, 2 store
    int m_addr = 0;
    int addr_seq = 0;

    always #5 clk = ~clk;

    qmove_core #(.ADDR_W(ADDR_W)) i_qmove_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr_i),
        .instr_valid_i (instr_valid_i),
        .eff_addr_i    (eff_addr_i),
        .fsel_o        (fsel_o),
        .bank_o        (bank_o),
        .phase_o       (phase_o),
        .w_o           (w_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_we_o      (mem_we_o)
    );

    function automatic int kind_of(input int word);
        if (((word >> 8) & 255) == 14) return 1;
        if (((word >> 9) & 127) == 55) return 2;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: advances with the clock, sampling inputs like the block should.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_w = 0; m_ir = 0; m_kind = 0; m_addr = 0;
        end else begin
            if (m_ph == 0) begin
                m_ir   = instr_valid_i ? int'(instr_i) : 0;
                m_kind = kind_of(m_ir);
            end else if (m_ph == 1) begin
                m_addr = int'(eff_addr_i);
            end else if (m_ph == 3 && m_kind == 1) begin
                m_w = m_ir & 255;
            end
            m_ph = (m_ph + 1) % 4;
        end
        started = 1;
    end

    // The address generator stand-in changes its output every clock.
    always @(negedge clk) begin
        addr_seq = addr_seq + 1;
        eff_addr_i <= ADDR_W'((addr_seq * 37 + 5) % 4096);
    end

    // Compare the outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 phase", int'(phase_o), m_ph);
            check(m_kind == 1 ? "R4 w" : (m_kind == 2 ? "R6 w" : "R8 w"), int'(w_o), m_w);
            check(m_kind == 2 ? "R5 we" : "R8 we", int'(mem_we_o), (m_ph == 3 && m_kind == 2) ? 1 : 0);
            if (m_ph == 3 && m_kind == 2) begin
                check("R5 addr", int'(mem_addr_o), m_addr);
                check("R5 data", int'(mem_wdata_o), m_w);
            end
            check("R7 fsel", int'(fsel_o), m_ir & 255);
            check("R7 bank", int'(bank_o), (m_ir >> 8) & 1);
        end
    end

    // Present a word for capture at Q1, then scramble the inputs for Q2 to Q4 (R3).
    task automatic issue(input logic [15:0] word, input logic vld);
        @(negedge clk);
        while (phase_o != 2'd0) @(negedge clk);
        instr_i = word;
        instr_valid_i = vld;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            instr_i = ~word;
            instr_valid_i = k[0];
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held under reset.
        check("R1 w", int'(w_o), 0);
        check("R1 phase", int'(phase_o), 0);
        check("R1 we", int'(mem_we_o), 0);
        rst_n = 1'b1;

        issue(16'h0E5A, 1'b1);            // R4 load
        issue(16'h6E20, 1'b1);            // R5 store a=0
        issue(16'h6FC3, 1'b1);            // R5 store a=1, right after a store
        @(negedge clk);
        while (phase_o != 2'd0) @(negedge clk);
        check("R6 w after store", int'(w_o), 8'h5A);
        issue(16'h0EFF, 1'b1);
        issue(16'h6E01, 1'b1);            // store 0xFF right after load
        issue(16'h1234, 1'b1);            // R8 unknown opcode
        issue(16'h0E77, 1'b0);            // R8 load without valid
        @(negedge clk);
        while (phase_o != 2'd0) @(negedge clk);
        check("R8 w after invalid", int'(w_o), 8'hFF);
        issue(16'h0E00, 1'b1);
        issue(16'h6F80, 1'b1);            // store 0x00
        @(negedge clk);
        while (phase_o != 2'd0) @(negedge clk);
        check("R3 w after scrambled inputs", int'(w_o), 8'h00);

        for (int n = 0; n < 400; n++) begin
            logic [15:0] word;
            int sel;
            sel = (n * 7 + 3) % 5;
            word = 16'((n * 40503 + 12345) & 16'hFFFF);
            if (sel == 0) word = {8'h0E, word[7:0]};
            else if (sel == 1 || sel == 2) word = {7'b0110111, word[8:0]};
            issue(word, (n % 9) != 4);
        end

        // R1: reset in mid-cycle returns the block to its initial state.
        issue(16'h0E3C, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 w mid reset", int'(w_o), 0);
        check("R1 phase mid reset", int'(phase_o), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule